// File: doc/BRIEF.md
# Clock and Supply Fault Injector

This block produces one precisely placed fault pulse on a target device, either on its clock or on its supply rails. In clock mode the target clock is the free-running source clock ORed with an internal glitch level, so while the glitch is high the target clock is held high. In the two supply modes the block drives two select lines to external analog multiplexers: one swaps the target's high-side rail for an alternate glitch voltage, the other swaps the low-side rail. A separate enable line can cut the supply from the target entirely. Analog switches and clock generation sit outside the block.

Software writes a mode, a delay and a width (both counted in cycles of the sequencer clock) and then arms the sequencer. The next rising edge on the external trigger input passes through a two-flop synchronizer. After the programmed delay it starts a pulse lasting the programmed number of cycles. Pulse placement and width therefore resolve to one period of the sequencer clock, which can run faster than the surrounding logic (10 ns steps at 100 MHz). Each arming yields at most one pulse.

Top module: `fault_injector`

## Requirements
- R1: After reset the glitch level, both select lines and the busy flag are low, the supply enable is high, and the mode, delay and width registers read back as zero.
- R2: Register addresses are: 0 = mode (bits 1:0), 1 = delay, 2 = width, 3 = control. A control write with bit 0 set arms the sequencer, and bit 1 sets the disconnect level. A read of address 3 returns busy in bit 0 and disconnect in bit 1. Addresses 0 to 2 read back the value written. Mode codes: 00 off, 01 clock glitch, 10 high-side supply glitch, 11 low-side supply glitch.
- R3: A pulse is started only by a low-to-high change of the trigger input while armed. Counting the first clock edge that sees the trigger high as edge 1, the pulse output becomes active after edge 3 + delay.
- R4: The pulse stays active for exactly width cycles. A width of zero gives no pulse and the sequencer returns to idle.
- R5: In clock mode the target clock output equals the source clock OR the glitch level. With the source clock low, the output is high exactly during the pulse.
- R6: High-side mode pulses only the high-side select line and low-side mode only the low-side line. The two lines are never high together, and mode off pulses nothing.
- R7: One arming gives at most one pulse. Trigger edges while the sequencer is not armed are ignored.
- R8: Busy is high from the clock edge that accepts an arm until the pulse ends. Writes to mode, delay and width while busy are ignored. An arm while busy has no effect.
- R9: The supply enable output is the inverse of the stored disconnect bit. That bit is written by every control write, busy or not, and is independent of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data for reg_addr_i |
| trig_i | input | 1 | Asynchronous external trigger |
| src_clk_i | input | 1 | Free-running target source clock |
| tgt_clk_o | output | 1 | Target clock: source OR glitch |
| sel_hi_o | output | 1 | Selects glitch voltage on the high-side rail |
| sel_lo_o | output | 1 | Selects glitch voltage on the low-side rail |
| supply_oe_o | output | 1 | Supply multiplexer enable (low disconnects) |
| busy_o | output | 1 | Armed or pulse in progress |

## Verification
Shots are fired in each of the three active modes with differing delay and width pairs, including a zero delay and a one-cycle width. A wrong start edge, an off-by-one count or a crossed select line then shows up as a mismatch in start cycle, length or output line. Zero width and mode off must give busy without any pulse. That separates the counters from the output decode. Triggers sent without a fresh arm, or before arming, must give no pulse, which exercises the one-shot rule. A delay rewritten while busy must leave both the readback and the measured start unchanged.

// File: rtl/fi_pkg.sv
package fi_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_CLK = 2'b01,
    MODE_HI  = 2'b10,
    MODE_LO  = 2'b11
  } fault_mode_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_ARMED,
    SEQ_DELAY,
    SEQ_PULSE
  } seq_state_e;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_DELAY = 2'd1;
  localparam logic [1:0] ADDR_WIDTH = 2'd2;
  localparam logic [1:0] ADDR_CTRL  = 2'd3;
endpackage

// File: rtl/fi_regs.sv
module fi_regs
  import fi_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             busy_i,
  output fault_mode_e      mode_o,
  output logic [CNT_W-1:0] delay_o,
  output logic [CNT_W-1:0] width_o,
  output logic             arm_o,
  output logic             disc_o
);
  logic cfg_open;
  logic mode_en, delay_en, width_en, ctrl_en;
  fault_mode_e mode_q;
  logic [CNT_W-1:0] delay_q, width_q;
  logic disc_q;

  assign cfg_open = we_i && !busy_i;
  assign mode_en  = cfg_open && (addr_i == ADDR_MODE);
  assign delay_en = cfg_open && (addr_i == ADDR_DELAY);
  assign width_en = cfg_open && (addr_i == ADDR_WIDTH);
  assign ctrl_en  = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_OFF;
      delay_q <= '0;
      width_q <= '0;
      disc_q  <= 1'b0;
    end else begin
      if (mode_en)  mode_q  <= fault_mode_e'(wdata_i[1:0]);
      if (delay_en) delay_q <= wdata_i;
      if (width_en) width_q <= wdata_i;
      if (ctrl_en)  disc_q  <= wdata_i[1];
    end
  end

  assign arm_o   = ctrl_en && wdata_i[0];
  assign mode_o  = mode_q;
  assign delay_o = delay_q;
  assign width_o = width_q;
  assign disc_o  = disc_q;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_MODE:  rdata_o[1:0] = mode_q;
      ADDR_DELAY: rdata_o      = delay_q;
      ADDR_WIDTH: rdata_o      = width_q;
      default:    rdata_o[1:0] = {disc_q, busy_i};
    endcase
  end
endmodule

// File: rtl/fi_trig_sync.sv
module fi_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] && !last_q;
endmodule

// File: rtl/fi_sequencer.sv
module fi_sequencer
  import fi_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             trig_rise_i,
  input  logic [CNT_W-1:0] delay_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             busy_o,
  output logic             pulse_nxt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      SEQ_IDLE: begin
        if (arm_i) state_d = SEQ_ARMED;
      end
      SEQ_ARMED: begin
        if (trig_rise_i) begin
          if (delay_i != '0) begin
            state_d = SEQ_DELAY;
            cnt_d   = delay_i;
          end else if (width_i != '0) begin
            state_d = SEQ_PULSE;
            cnt_d   = width_i;
          end else begin
            state_d = SEQ_IDLE;
          end
        end
      end
      SEQ_DELAY: begin
        if (cnt_q == ONE) begin
          if (width_i != '0) begin
            state_d = SEQ_PULSE;
            cnt_d   = width_i;
          end else begin
            state_d = SEQ_IDLE;
          end
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
      default: begin
        if (cnt_q == ONE) state_d = SEQ_IDLE;
        else              cnt_d   = cnt_q - ONE;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o      = (state_q != SEQ_IDLE);
  assign pulse_nxt_o = (state_d == SEQ_PULSE);
endmodule

// File: rtl/fi_out_stage.sv
module fi_out_stage
  import fi_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        pulse_nxt_i,
  input  fault_mode_e mode_i,
  output logic        glitch_o,
  output logic        sel_hi_o,
  output logic        sel_lo_o
);
  logic glitch_d, hi_d, lo_d;
  logic glitch_q, hi_q, lo_q;

  always_comb begin
    glitch_d = 1'b0;
    hi_d     = 1'b0;
    lo_d     = 1'b0;
    if (pulse_nxt_i) begin
      case (mode_i)
        MODE_CLK: glitch_d = 1'b1;
        MODE_HI:  hi_d     = 1'b1;
        MODE_LO:  lo_d     = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glitch_q <= 1'b0;
      hi_q     <= 1'b0;
      lo_q     <= 1'b0;
    end else begin
      glitch_q <= glitch_d;
      hi_q     <= hi_d;
      lo_q     <= lo_d;
    end
  end

  assign glitch_o = glitch_q;
  assign sel_hi_o = hi_q;
  assign sel_lo_o = lo_q;
endmodule

// File: rtl/fault_injector.sv
module fault_injector
  import fi_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [CNT_W-1:0] reg_wdata_i,
  output logic [CNT_W-1:0] reg_rdata_o,
  input  logic             trig_i,
  input  logic             src_clk_i,
  output logic             tgt_clk_o,
  output logic             sel_hi_o,
  output logic             sel_lo_o,
  output logic             supply_oe_o,
  output logic             busy_o
);
  fault_mode_e      cfg_mode;
  logic [CNT_W-1:0] cfg_delay, cfg_width;
  logic             arm, disc, trig_rise, pulse_nxt, glitch_act;

  fi_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .busy_i  (busy_o),
    .mode_o  (cfg_mode),
    .delay_o (cfg_delay),
    .width_o (cfg_width),
    .arm_o   (arm),
    .disc_o  (disc)
  );

  fi_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (trig_i),
    .rise_o  (trig_rise)
  );

  fi_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm),
    .trig_rise_i (trig_rise),
    .delay_i     (cfg_delay),
    .width_i     (cfg_width),
    .busy_o      (busy_o),
    .pulse_nxt_o (pulse_nxt)
  );

  fi_out_stage u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pulse_nxt_i (pulse_nxt),
    .mode_i      (cfg_mode),
    .glitch_o    (glitch_act),
    .sel_hi_o    (sel_hi_o),
    .sel_lo_o    (sel_lo_o)
  );

  assign tgt_clk_o   = src_clk_i | glitch_act;
  assign supply_oe_o = !disc;
endmodule

// File: rtl/fault_injector_chk.sv
module fault_injector_chk
  import fi_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic [CNT_W-1:0] reg_wdata_i,
  input logic             sel_hi_o,
  input logic             sel_lo_o,
  input logic             supply_oe_o,
  input logic             busy_o,
  input logic             glitch_act,
  input fault_mode_e      cfg_mode,
  input logic [CNT_W-1:0] cfg_delay,
  input logic [CNT_W-1:0] cfg_width
);
  AST_SEL_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_hi_o && sel_lo_o)); // R6

  AST_ONE_FAULT_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({glitch_act, sel_hi_o, sel_lo_o}) <= 1); // R6

  AST_GLITCH_CLK_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    glitch_act |-> (cfg_mode == MODE_CLK)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(glitch_act || sel_hi_o || sel_lo_o)); // R8

  AST_ARM_SETS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_CTRL && reg_wdata_i[0] && !busy_o) |=> busy_o); // R8

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_we_i && reg_addr_i != ADDR_CTRL)
      |=> ($stable(cfg_mode) && $stable(cfg_delay) && $stable(cfg_width))); // R8

  AST_DISCONNECT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_CTRL) |=> (supply_oe_o == !$past(reg_wdata_i[1]))); // R9
endmodule

bind fault_injector fault_injector_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .sel_hi_o    (sel_hi_o),
  .sel_lo_o    (sel_lo_o),
  .supply_oe_o (supply_oe_o),
  .busy_o      (busy_o),
  .glitch_act  (glitch_act),
  .cfg_mode    (cfg_mode),
  .cfg_delay   (cfg_delay),
  .cfg_width   (cfg_width)
);

// File: tb/fault_injector_tb.sv
module fault_injector_tb;
  logic        clk, rst_n;
  logic        we;
  logic [1:0]  addr;
  logic [15:0] wdata, rdata;
  logic        trig, src_clk;
  logic        tgt_clk, sel_hi, sel_lo, oe, busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  int exp_start[$];
  int exp_len[$];
  int exp_kind[$];

  fault_injector u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .trig_i(trig),
    .src_clk_i(src_clk), .tgt_clk_o(tgt_clk), .sel_hi_o(sel_hi),
    .sel_lo_o(sel_lo), .supply_oe_o(oe), .busy_o(busy)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measures every fault pulse (source clock held low) and pops the scoreboard.
  logic mon_prev = 1'b0;
  int   mon_start = 0, mon_len = 0, mon_kind = 0;
  always @(negedge clk) begin
    logic act;
    act = rst_n && (tgt_clk || sel_hi || sel_lo) && !src_clk;
    if (act && !mon_prev) begin
      mon_start = cyc;
      mon_len   = 0;
      mon_kind  = tgt_clk ? 1 : (sel_hi ? 2 : 3);
    end
    if (act) mon_len++;
    if (!act && mon_prev) begin
      if (exp_start.size() == 0) begin
        check("R7 unexpected pulse start", mon_start, -1);
      end else begin
        check("R3 pulse start cycle", mon_start, exp_start.pop_front());
        check("R4 pulse width", mon_len, exp_len.pop_front());
        check("R6 pulse line (1 clk 2 hi 3 lo)", mon_kind, exp_kind.pop_front());
      end
    end
    mon_prev = act;
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk);
    addr = a;
    #1 v = int'(rdata);
  endtask

  // Driver: raises the trigger and pushes the expected pulse, if any.
  task automatic shot(input int kind, input int d, input int w, input bit expect_pulse);
    @(negedge clk);
    trig = 1'b1;
    if (expect_pulse) begin
      exp_start.push_back(cyc + 3 + d);
      exp_len.push_back(w);
      exp_kind.push_back(kind);
    end
    repeat (4) @(negedge clk);
    trig = 1'b0;
    repeat (d + w + 8) @(negedge clk);
  endtask

  task automatic setup(input int mode, input int d, input int w);
    wr(2'd0, 16'(mode));
    wr(2'd1, 16'(d));
    wr(2'd2, 16'(w));
  endtask

  initial begin
    int v;
    we = 0; addr = 0; wdata = 0; trig = 0; src_clk = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 glitch/clock low", int'(tgt_clk), 0);
    check("R1 sel_hi low", int'(sel_hi), 0);
    check("R1 sel_lo low", int'(sel_lo), 0);
    check("R1 supply enable high", int'(oe), 1);
    check("R1 busy low", int'(busy), 0);
    rd(2'd1, v); check("R1 delay reset", v, 0);

    // R2 register readback
    setup(2'b01, 5, 3);
    rd(2'd0, v); check("R2 mode readback", v, 1);
    rd(2'd1, v); check("R2 delay readback", v, 5);
    rd(2'd2, v); check("R2 width readback", v, 3);

    // R5 OR with source clock while idle
    src_clk = 1; #1 check("R5 source high passes", int'(tgt_clk), 1);
    src_clk = 0; #1 check("R5 source low, no glitch", int'(tgt_clk), 0);

    // R3 R4 R5 clock mode, delay 5 width 3
    wr(2'd3, 16'h1);
    rd(2'd3, v); check("R8 busy after arm", v & 1, 1);
    shot(1, 5, 3, 1);
    rd(2'd3, v); check("R8 busy clear after pulse", v & 1, 0);

    // R7 second trigger without re-arm
    shot(1, 5, 3, 0);

    // R6 high side, zero delay, one cycle
    setup(2'b10, 0, 1);
    wr(2'd3, 16'h1);
    shot(2, 0, 1, 1);

    // R6 low side, delay 10 width 7
    setup(2'b11, 10, 7);
    wr(2'd3, 16'h1);
    shot(3, 10, 7, 1);

    // R4 width zero: no pulse, busy drops
    setup(2'b10, 2, 0);
    wr(2'd3, 16'h1);
    shot(2, 2, 0, 0);
    check("R4 width zero returns idle", int'(busy), 0);

    // R6 mode off: busy cycle without pulse
    setup(2'b00, 1, 4);
    wr(2'd3, 16'h1);
    shot(0, 1, 4, 0);
    check("R6 mode off idle again", int'(busy), 0);

    // R7 trigger before arming is ignored
    setup(2'b01, 2, 2);
    shot(1, 2, 2, 0);
    wr(2'd3, 16'h1);
    check("R7 still armed after ignored trigger", int'(busy), 1);
    shot(1, 2, 2, 1);

    // R8 config write while busy is ignored
    setup(2'b11, 4, 2);
    wr(2'd3, 16'h1);
    wr(2'd1, 16'd9);
    wr(2'd0, 16'd1);
    rd(2'd1, v); check("R8 delay frozen while busy", v, 4);
    rd(2'd0, v); check("R8 mode frozen while busy", v, 3);
    shot(3, 4, 2, 1);

    // R9 disconnect written any time
    wr(2'd3, 16'h2);
    @(negedge clk);
    check("R9 disconnect drops enable", int'(oe), 0);
    rd(2'd3, v); check("R9 disconnect readback", (v >> 1) & 1, 1);
    check("R9 no arm from disconnect write", v & 1, 0);
    wr(2'd3, 16'h0);
    @(negedge clk);
    check("R9 reconnect raises enable", int'(oe), 1);

    repeat (5) @(negedge clk);
    check("R3 all expected pulses seen", exp_start.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule